// File: doc/BRIEF.md
# MASH Four-Stage Noise-Cancellation Combiner

This block is the digital recombination filter that sits behind a cascade of four first-order delta-sigma stages. On every sample each stage hands over a 2-bit code from its 4-level quantizer. The combiner turns each code into a signed level and gives each stage its own path. The path for stage k applies k−1 first differences (1−z⁻¹) and a delay that pads every path to the same total latency of three samples. A left shift then restores the power-of-two gain that the analog side divided away between stages. All four paths are added into a single signed word that is wide enough never to overflow.

When the analog cascade feeds each stage with the previous stage's negated, halved quantization error, the quantization errors of the first three stages cancel in the sum. Only the input, delayed, and the last stage's error shaped by a fourth-order difference remain. A sample enters when `validIn` is high. The result appears on `outWord` one clock later, with `validOut` high for that clock. Clocks with `validIn` low move nothing.

Top module: `mash_noise_cancel`

## Requirements
- R1: Each 2-bit stage code c maps to the signed level 2c−3: code 0 → −3, code 1 → −1, code 2 → +1, code 3 → +3. Stage 1 uses bits [1:0] of `stageCodes`, stage 2 bits [3:2], stage 3 bits [5:4] and stage 4 bits [7:6].
- R2: The stage-1 path adds its level delayed by three samples, with unit gain.
- R3: The stage-2 path adds 2·(L2[n−2] − L2[n−3]).
- R4: The stage-3 path adds 4·Δ²L3 taken at sample n−1.
- R5: The stage-4 path adds 8·Δ³L4 at sample n, with no delay.
- R6: `outWord` is the two's-complement sum of the four paths and is 9 bits wide by default. Its magnitude never exceeds 255, and an input pattern exists that reaches ±255.
- R7: `validOut` is high exactly in the clock after a clock with `validIn` high. `outWord` takes the new sample's result in that same clock.
- R8: A clock with `validIn` low changes neither `outWord` nor any filter history. The next valid sample behaves as if the idle clock had not happened.
- R9: A synchronous reset (`rst` high at a clock edge) clears `outWord`, `validOut` and every delay and difference register to zero. After reset, past samples count as level 0.
- R10: When the codes come from an ideal first-order cascade (each stage has output z⁻¹·u + (1−z⁻¹)·e, and stage k+1 takes −e_k/2), `outWord` equals the cascade input delayed by four samples plus 8·(1−z⁻¹)⁴ applied to the last stage's error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | The codes on this clock form a new sample |
| stageCodes | input | 8 | Four 2-bit quantizer codes, stage 1 in the low bits |
| validOut | output | 1 | `outWord` holds a new result |
| outWord | output | 9 | Signed combined output |

## Verification
Embedded properties check three things on every clock: the one-clock valid relationship, that idle clocks leave the output unchanged, and that reset clears the output. They also keep each shaped path within its 3·2^(k−1) bound and the total within ±255. Only the bench's scenarios can show that each path has the right delay, difference order and gain. The same holds for the exact code-to-level table, and for history that survives idle gaps but not a reset. Most of all, only the scenarios can show that an ideal cascade's errors cancel down to the shaped error of the last stage. The bench compares every clock against a behavioural model that sums binomially weighted histories. It also runs a real-valued cascade model for the cancellation test.

// File: rtl/mash_cmb_pkg.sv
package mash_cmb_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic advance;   // shift a new sample through every path
    logic clear;     // zero all histories and the output
  } ctrl_strobe_t;

  // Largest |sum|: level peak times sum of (diff gain 2^k)*(shift gain 2^(k*g))
  function automatic int peakMag(input int stages, input int gainShift, input int codeW);
    int acc;
    int maxLvl;
    acc    = 0;
    maxLvl = (1 << codeW) - 1;
    for (int k = 0; k < stages; k++) begin
      acc += maxLvl << (k * (gainShift + 1));
    end
    return acc;
  endfunction

  function automatic int outWidth(input int stages, input int gainShift, input int codeW);
    return $clog2(peakMag(stages, gainShift, codeW) + 1) + 1;
  endfunction

endpackage

// File: rtl/mash_cmb_ctrl.sv
module mash_cmb_ctrl
  import mash_cmb_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         validIn,
  output ctrl_strobe_t strobe,
  output logic         validOut
);

  always_comb begin
    strobe.clear   = rst;
    strobe.advance = validIn & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) validOut <= 1'b0;
    else     validOut <= validIn;
  end

  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    validIn |=> validOut);

  // R7
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !validIn |=> !validOut);

endmodule

// File: rtl/mash_cmb_datapath.sv
module mash_cmb_datapath
  import mash_cmb_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int CODE_W     = 2,
  parameter int GAIN_SHIFT = 1,
  parameter int OUT_W      = 9
) (
  input  logic                          clk,
  input  ctrl_strobe_t                  strobe,
  input  logic [NUM_STAGES*CODE_W-1:0]  stageCodes,
  output logic signed [OUT_W-1:0]       sumOut
);

  localparam int MAX_LVL = (1 << CODE_W) - 1;
  localparam int PEAK    = peakMag(NUM_STAGES, GAIN_SHIFT, CODE_W);

  logic signed [OUT_W-1:0] pathBus [NUM_STAGES];

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    localparam int DLY   = NUM_STAGES - 1 - s;
    localparam int BOUND = MAX_LVL << s;

    logic [CODE_W-1:0]       code;
    logic signed [OUT_W-1:0] lvl;
    logic signed [OUT_W-1:0] shaped;
    logic signed [OUT_W-1:0] aligned;

    assign code = stageCodes[s*CODE_W +: CODE_W];
    // level = 2*code - MAX_LVL
    assign lvl  = $signed({{(OUT_W-CODE_W-1){1'b0}}, code, 1'b0}) - $signed(OUT_W'(MAX_LVL));

    if (s == 0) begin : g_nodiff
      assign shaped = lvl;
    end else begin : g_diff
      logic signed [OUT_W-1:0] prevR [s];
      logic signed [OUT_W-1:0] tap   [s+1];
      always_comb begin
        tap[0] = lvl;
        for (int j = 0; j < s; j++) tap[j+1] = tap[j] - prevR[j];
      end
      always_ff @(posedge clk) begin
        if (strobe.clear) begin
          for (int j = 0; j < s; j++) prevR[j] <= '0;
        end else if (strobe.advance) begin
          for (int j = 0; j < s; j++) prevR[j] <= tap[j];
        end
      end
      assign shaped = tap[s];
    end

    if (DLY == 0) begin : g_nodly
      assign aligned = shaped;
    end else begin : g_dly
      logic signed [OUT_W-1:0] dlyR [DLY];
      always_ff @(posedge clk) begin
        if (strobe.clear) begin
          for (int i = 0; i < DLY; i++) dlyR[i] <= '0;
        end else if (strobe.advance) begin
          dlyR[0] <= shaped;
          for (int i = 1; i < DLY; i++) dlyR[i] <= dlyR[i-1];
        end
      end
      assign aligned = dlyR[DLY-1];
    end

    assign pathBus[s] = aligned <<< (s * GAIN_SHIFT);

    // R6
    diff_bound_chk: assert property (@(posedge clk) disable iff (strobe.clear)
      (shaped <= BOUND) && (shaped >= -BOUND));
  end

  logic signed [OUT_W-1:0] sumNext;
  always_comb begin
    sumNext = '0;
    for (int s = 0; s < NUM_STAGES; s++) sumNext = sumNext + pathBus[s];
  end

  always_ff @(posedge clk) begin
    if (strobe.clear)        sumOut <= '0;
    else if (strobe.advance) sumOut <= sumNext;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    (sumOut <= PEAK) && (sumOut >= -PEAK));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.advance |=> $stable(sumOut));

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (strobe.clear)
    $past(strobe.clear) |-> (sumOut == '0));

endmodule

// File: rtl/mash_noise_cancel.sv
module mash_noise_cancel
  import mash_cmb_pkg::*;
#(
  parameter int NUM_STAGES = 4,
  parameter int CODE_W     = 2,
  parameter int GAIN_SHIFT = 1
) (
  input  logic                                                   clk,
  input  logic                                                   rst,
  input  logic                                                   validIn,
  input  logic [NUM_STAGES*CODE_W-1:0]                           stageCodes,
  output logic                                                   validOut,
  output logic signed [outWidth(NUM_STAGES,GAIN_SHIFT,CODE_W)-1:0] outWord
);

  localparam int OUT_W = outWidth(NUM_STAGES, GAIN_SHIFT, CODE_W);

  ctrl_strobe_t strobe;

  mash_cmb_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .validIn  (validIn),
    .strobe   (strobe),
    .validOut (validOut)
  );

  mash_cmb_datapath #(
    .NUM_STAGES (NUM_STAGES),
    .CODE_W     (CODE_W),
    .GAIN_SHIFT (GAIN_SHIFT),
    .OUT_W      (OUT_W)
  ) u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .stageCodes (stageCodes),
    .sumOut     (outWord)
  );

endmodule

// File: tb/mash_noise_cancel_tb.sv
module mash_noise_cancel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OUT_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic validIn = 1'b0;
  logic [7:0] stageCodes = '0;
  logic validOut;
  logic signed [OUT_W-1:0] outWord;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  int lastOut = 0;
  int hist[4][$];
  int c1q[$];
  real uHist[$];
  real e4Hist[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  mash_noise_cancel u_dut (
    .clk(clk), .rst(rst), .validIn(validIn), .stageCodes(stageCodes),
    .validOut(validOut), .outWord(outWord)
  );

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected=<50000", cycles);
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int histAt(input int k, input int m);
    return (m < hist[k].size()) ? hist[k][m] : 0;
  endfunction

  function automatic int binom(input int n, input int r);
    int v = 1;
    for (int i = 0; i < r; i++) v = v * (n - i) / (i + 1);
    return v;
  endfunction

  // y = sum_k 2^k * (1-z^-1)^k z^-(3-k) L_k
  function automatic int modelOut();
    int y = 0;
    for (int k = 0; k < 4; k++) begin
      int acc = 0;
      for (int j = 0; j <= k; j++)
        acc += binom(k, j) * ((j % 2) ? -1 : 1) * histAt(k, 3 - k + j);
      y += acc * (1 << k);
    end
    return y;
  endfunction

  task automatic clearModel();
    for (int k = 0; k < 4; k++) hist[k].delete();
    c1q.delete();
    uHist.delete();
    e4Hist.delete();
    lastOut = 0;
  endtask

  // drive at negedge, check at next negedge
  task automatic step(input bit v, input int c0, input int c1, input int c2, input int c3,
                      input string req);
    int cs[4];
    int exp;
    cs = '{c0, c1, c2, c3};
    validIn = v;
    stageCodes = {2'(c3), 2'(c2), 2'(c1), 2'(c0)};
    @(negedge clk);
    if (v) begin
      for (int k = 0; k < 4; k++) begin
        hist[k].push_front(2 * cs[k] - 3);
        if (hist[k].size() > 8) void'(hist[k].pop_back());
      end
      c1q.push_front(c0);
      if (c1q.size() > 8) void'(c1q.pop_back());
      exp = modelOut();
      chk(validOut == 1'b1, {req, " R7 validOut"}, int'(validOut), 1);
      chk(int'(outWord) == exp, req, int'(outWord), exp);
      lastOut = exp;
    end else begin
      chk(validOut == 1'b0, {req, " R7 idle validOut"}, int'(validOut), 0);
      chk(int'(outWord) == lastOut, {req, " R8 hold"}, int'(outWord), lastOut);
    end
  endtask

  task automatic doReset();
    rst = 1'b1;
    validIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    clearModel();
    chk(int'(outWord) == 0, "R9 outWord after reset", int'(outWord), 0);
    chk(validOut == 1'b0, "R9 validOut after reset", int'(validOut), 0);
  endtask

  initial begin
    int lvlTab[4];
    lvlTab = '{-3, -1, 1, 3};
    @(negedge clk);
    doReset();

    // R1 R2: stage 1 alone after the other paths settle
    for (int n = 0; n < 8; n++) step(1, 0, 1, 1, 1, "R2 settle");
    for (int n = 0; n < 12; n++) begin
      step(1, n % 4, 1, 1, 1, "R2 path1");
      chk(int'(outWord) == lvlTab[c1q[3]], "R1 level map", int'(outWord), lvlTab[c1q[3]]);
    end

    // R3: stage 2 varies
    for (int n = 0; n < 12; n++) step(1, 2, (n * 3) % 4, 2, 2, "R3 path2");
    // R4: stage 3 varies
    for (int n = 0; n < 12; n++) step(1, 2, 2, (n * n) % 4, 2, "R4 path3");
    // R5: stage 4 varies
    for (int n = 0; n < 12; n++) step(1, 2, 2, 2, (n / 2) % 4, "R5 path4");

    // R6: phased alternation reaches full scale
    for (int n = 0; n < 12; n++) begin
      step(1, (n % 2) ? 3 : 0, ((n + 1) % 2) ? 3 : 0, (n % 2) ? 3 : 0,
           ((n + 1) % 2) ? 3 : 0, "R6 full scale");
      if (n >= 6) chk(outWord == 255 || outWord == -255, "R6 peak",
                      int'(outWord), 255);
    end

    // R7 R8: random codes with idle gaps
    for (int n = 0; n < 200; n++) begin
      bit v;
      v = ($urandom_range(0, 3) != 0);
      step(v, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           $urandom_range(0, 3), "R8 random gaps");
    end

    // R9: mid-run reset then fresh history
    doReset();
    for (int n = 0; n < 10; n++) step(1, 3, 0, 3, 0, "R9 post reset");

    // R10: ideal cascade cancellation
    doReset();
    begin
      real uPrev[4];
      real ePrev[4];
      for (int k = 0; k < 4; k++) begin uPrev[k] = 0.0; ePrev[k] = 0.0; end
      for (int n = 0; n < 300; n++) begin
        real u;
        real w;
        real e;
        real expR;
        real d4;
        int code[4];
        u = 2.5 * $sin(2.0 * 3.14159265 * n / 37.0);
        uHist.push_front(u);
        for (int k = 0; k < 4; k++) begin
          real uk;
          int c;
          uk = (k == 0) ? u : -e / 2.0;
          w = uPrev[k] - ePrev[k];
          c = $rtoi((w + 3.0) / 2.0 + 0.5);
          if (c < 0) c = 0;
          if (c > 3) c = 3;
          code[k] = c;
          e = (2.0 * c - 3.0) - w;
          uPrev[k] = uk;
          ePrev[k] = e;
        end
        e4Hist.push_front(e);
        step(1, code[0], code[1], code[2], code[3], "R10 cascade model");
        d4 = 0.0;
        for (int j = 0; j <= 4; j++)
          if (j < e4Hist.size())
            d4 += binom(4, j) * ((j % 2) ? -1.0 : 1.0) * e4Hist[j];
        expR = 8.0 * d4 + ((uHist.size() > 4) ? uHist[4] : 0.0);
        checks++;
        if ((outWord - expR) > 1.0e-6 || (expR - outWord) > 1.0e-6) begin
          errors++;
          $display("FAIL R10 cancellation: actual=%0d expected=%f", int'(outWord), expR);
        end
      end
    end

    summary();
  end
endmodule